// File: doc/BRIEF.md
# NEC Infrared Remote Transmitter

This block sends NEC-style infrared remote frames on a single LED drive pin. A requester presents a 16-bit address and a 16-bit command and pulses a start request. The block then plays out a leader, 32 pulse-distance coded bits and a closing burst. Marks carry a square-wave carrier at 50% duty, and the pin stays low during spaces and while idle. A second request input sends the short repeat frame instead. The requester alone decides when repeats go out.

All timing is counted in microseconds from a per-segment prescaler on the system clock. Every mark and space length is a parameter, so a bench can shrink them without changing the structure. A busy flag covers the whole transmission. Any request raised while busy has no effect.

Top module: `nec_ir_tx`

## Requirements
- R1: After reset, and with no request, `busy` and `ir_out` are both 0.
- R2: A request accepted at a clock edge while idle starts the leader mark in the next cycle. The leader is LEAD_MARK_US microseconds of carrier, then LEAD_SPACE_US microseconds of silence. One microsecond is CLK_HZ/1e6 clock cycles.
- R3: During a mark, `ir_out` is high for the first HALF cycles of each 2*HALF cycle period, where HALF = CLK_HZ/(2*CARRIER_HZ). The carrier phase restarts at the first cycle of every mark. `ir_out` is 0 during spaces and while idle.
- R4: If the supplied address is below 256 (bits 15:8 all zero), the address sent has the supplied byte as bits 7:0 and its bitwise complement as bits 15:8. Any other address is sent unchanged.
- R5: The payload is the 16 address bits followed by the 16 command bits. Each field goes out starting with bit 0.
- R6: Each payload bit is a BURST_US mark followed by a space. The space lasts BURST_US for a 0 and ONE_SPACE_US for a 1.
- R7: The frame ends with one BURST_US mark. `busy` is 1 in every cycle from the leader's first cycle to the closing mark's last cycle, and 0 in the cycle after that.
- R8: A repeat request sends a LEAD_MARK_US mark, then a REP_SPACE_US space, then one BURST_US mark, with the same `busy` behaviour.
- R9: A start or repeat request while `busy` is 1 is ignored, including one in the last busy cycle. The frame in flight is unchanged and no second frame follows.
- R10: When start and repeat are raised in the same idle cycle, the full data frame is sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a full data frame |
| repeat_i | input | 1 | Request a repeat frame |
| addr_i | input | 16 | Address, captured when a request is accepted |
| cmd_i | input | 16 | Command word, captured when a request is accepted |
| busy | output | 1 | Transmission in progress |
| ir_out | output | 1 | Carrier-gated LED drive |

## Verification
Two cases can fall in one cycle. The first is a start and a repeat request raised together while idle. The bench raises both in the same idle cycle and requires the full data-frame waveform to come out cycle for cycle. The second is a new request landing in the closing mark's last cycle, just as the sequencer returns to idle. The bench injects start and repeat mid-frame and again in that last busy cycle. It then requires the original waveform to be unchanged and `busy` to read 0 in the following cycle.

// File: rtl/nec_ir_tx.sv
module nec_ir_tx #(
  parameter int CLK_HZ        = 50_000_000,
  parameter int CARRIER_HZ    = 38_000,
  parameter int LEAD_MARK_US  = 9000,
  parameter int LEAD_SPACE_US = 4500,
  parameter int REP_SPACE_US  = 2250,
  parameter int BURST_US      = 562,
  parameter int ONE_SPACE_US  = 1687
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        repeat_i,
  input  logic [15:0] addr_i,
  input  logic [15:0] cmd_i,
  output logic        busy,
  output logic        ir_out
);
  localparam int TPU  = CLK_HZ / 1_000_000;
  localparam int HALF = CLK_HZ / (2 * CARRIER_HZ);
  localparam int PW   = (TPU > 1) ? $clog2(TPU) : 1;
  localparam int CW   = (2 * HALF > 1) ? $clog2(2 * HALF) : 1;
  localparam int M1   = (LEAD_MARK_US > LEAD_SPACE_US) ? LEAD_MARK_US : LEAD_SPACE_US;
  localparam int M2   = (REP_SPACE_US > M1) ? REP_SPACE_US : M1;
  localparam int M3   = (BURST_US > M2) ? BURST_US : M2;
  localparam int MAXD = (ONE_SPACE_US > M3) ? ONE_SPACE_US : M3;
  localparam int UW   = $clog2(MAXD + 1);

  typedef enum logic [2:0] {S_IDLE, S_LEAD_M, S_LEAD_S, S_BIT_M, S_BIT_S, S_TAIL_M} st_t;

  st_t          st, nxt;
  logic [PW-1:0] pre;
  logic [UW-1:0] us, dur;
  logic [CW-1:0] cc;
  logic [31:0]   payload;
  logic [4:0]    bit_idx;
  logic          rep;
  logic [15:0]   ext_addr;
  logic          is_mark, seg_end;

  assign ext_addr = (addr_i[15:8] == 8'h00) ? {~addr_i[7:0], addr_i[7:0]} : addr_i;
  assign is_mark  = (st == S_LEAD_M) || (st == S_BIT_M) || (st == S_TAIL_M);
  assign busy     = (st != S_IDLE);
  assign ir_out   = is_mark && (cc < CW'(HALF));
  assign seg_end  = (pre == PW'(TPU - 1)) && (us == dur - UW'(1));

  always_comb begin
    dur = UW'(BURST_US);
    nxt = S_IDLE;
    case (st)
      S_LEAD_M: begin dur = UW'(LEAD_MARK_US); nxt = S_LEAD_S; end
      S_LEAD_S: begin
        dur = rep ? UW'(REP_SPACE_US) : UW'(LEAD_SPACE_US);
        nxt = rep ? S_TAIL_M : S_BIT_M;
      end
      S_BIT_M:  begin dur = UW'(BURST_US); nxt = S_BIT_S; end
      S_BIT_S:  begin
        dur = payload[0] ? UW'(ONE_SPACE_US) : UW'(BURST_US);
        nxt = (bit_idx == 5'd31) ? S_TAIL_M : S_BIT_M;
      end
      S_TAIL_M: begin dur = UW'(BURST_US); nxt = S_IDLE; end
      default:  begin dur = UW'(BURST_US); nxt = S_IDLE; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      pre     <= '0;
      us      <= '0;
      cc      <= '0;
      payload <= '0;
      bit_idx <= '0;
      rep     <= 1'b0;
    end else if (st == S_IDLE) begin
      if (start_i || repeat_i) begin
        st      <= S_LEAD_M;
        rep     <= !start_i;
        payload <= {cmd_i, ext_addr};
        bit_idx <= '0;
        pre     <= '0;
        us      <= '0;
        cc      <= '0;
      end
    end else begin
      cc <= (cc == CW'(2 * HALF - 1)) ? '0 : cc + CW'(1);
      if (pre == PW'(TPU - 1)) begin
        pre <= '0;
        if (seg_end) begin
          us <= '0;
          cc <= '0;
          st <= nxt;
          if (st == S_BIT_S) begin
            payload <= {1'b0, payload[31:1]};
            bit_idx <= bit_idx + 5'd1;
          end
        end else begin
          us <= us + UW'(1);
        end
      end else begin
        pre <= pre + PW'(1);
      end
    end
  end
endmodule

// File: rtl/nec_ir_tx_chk.sv
module nec_ir_tx_chk #(
  parameter int HALF = 1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       repeat_i,
  input logic       busy,
  input logic       ir_out,
  input logic       rep,
  input logic [4:0] bit_idx
);
  logic [15:0] hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_run <= '0;
    else if (ir_out) hi_run <= hi_run + 16'd1;
    else hi_run <= '0;
  end

  assert_idle_dark_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ir_out);

  assert_carrier_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ir_out |-> (hi_run < 16'(HALF)));

  assert_start_needs_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_i || repeat_i));

  assert_kind_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(rep));

  assert_bit_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bit_idx) |-> ((bit_idx == $past(bit_idx) + 5'd1) || (bit_idx == 5'd0)));
endmodule

bind nec_ir_tx nec_ir_tx_chk #(.HALF(HALF)) chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .repeat_i(repeat_i),
  .busy(busy), .ir_out(ir_out), .rep(rep), .bit_idx(bit_idx)
);

// File: tb/nec_ir_tx_test.sv
module nec_ir_tx_test;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ = 4_000_000;
  localparam int CAR_HZ = 1_000_000;
  localparam int LM = 20, LS = 10, RS = 5, BU = 2, OS = 5;
  localparam int TPU = CLK_HZ / 1_000_000;
  localparam int H = CLK_HZ / (2 * CAR_HZ);

  localparam logic [33:0] VEC [0:5] = '{
    {2'd0, 16'h00A5, 16'h1234},
    {2'd0, 16'h1C3E, 16'hFFFF},
    {2'd0, 16'h00FF, 16'h0000},
    {2'd0, 16'h0100, 16'h8001},
    {2'd1, 16'h0000, 16'h0000},
    {2'd2, 16'h0012, 16'hC3C3}
  };

  logic clk = 0, rst_n = 0, start_i = 0, repeat_i = 0;
  logic [15:0] addr_i = 0, cmd_i = 0;
  logic busy, ir_out;
  int checks = 0, failures = 0;
  int seg_len[$];
  bit seg_mark[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  nec_ir_tx #(.CLK_HZ(CLK_HZ), .CARRIER_HZ(CAR_HZ), .LEAD_MARK_US(LM), .LEAD_SPACE_US(LS),
              .REP_SPACE_US(RS), .BURST_US(BU), .ONE_SPACE_US(OS)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .repeat_i(repeat_i),
    .addr_i(addr_i), .cmd_i(cmd_i), .busy(busy), .ir_out(ir_out));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic add_seg(input bit m, input int us);
    seg_mark.push_back(m);
    seg_len.push_back(us * TPU);
  endtask

  task automatic build(input bit is_rep, input logic [15:0] a, input logic [15:0] c);
    logic [15:0] ea;
    logic [31:0] w;
    seg_len.delete();
    seg_mark.delete();
    ea = (a < 16'd256) ? {~a[7:0], a[7:0]} : a;
    w = {c, ea};
    add_seg(1, LM);
    if (is_rep) add_seg(0, RS);
    else begin
      add_seg(0, LS);
      for (int i = 0; i < 32; i++) begin
        add_seg(1, BU);
        add_seg(0, w[i] ? OS : BU);
      end
    end
    add_seg(1, BU);
  endtask

  task automatic play(input bit inj, input string req);
    int total = 0, mism = 0, seg = 0, k = 0, fc = -1, fa = 0, fe = 0;
    bit e;
    foreach (seg_len[i]) total += seg_len[i];
    for (int c = 0; c < total; c++) begin
      @(negedge clk);
      e = seg_mark[seg] && ((k % (2 * H)) < H);
      if (ir_out !== e || busy !== 1'b1) begin
        mism++;
        if (fc < 0) begin fc = c; fa = {busy, ir_out}; fe = {1'b1, e}; end
      end
      if (inj && (c == total / 2 || c == total - 1)) begin
        start_i = 1; repeat_i = 1; addr_i = 16'hFFFF; cmd_i = 16'h0000;
      end else begin
        start_i = 0; repeat_i = 0;
      end
      k++;
      if (k == seg_len[seg]) begin k = 0; seg++; end
    end
    if (fc >= 0) $display("first mismatch at cycle %0d", fc);
    check(mism == 0, {req, " waveform {busy,ir}"}, fa, fe);
    @(negedge clk);
    check(busy == 1'b0 && ir_out == 1'b0, {req, " R7 idle after frame"}, {busy, ir_out}, 0);
    start_i = 0; repeat_i = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        failures++;
        $display("FAIL watchdog R7 actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    string tag;
    #(CLK_PERIOD * 2 + 1);
    check(busy == 0 && ir_out == 0, "R1 in reset", {busy, ir_out}, 0);
    @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    check(busy == 0 && ir_out == 0, "R1 idle after reset", {busy, ir_out}, 0);

    for (int v = 0; v < 6; v++) begin
      wait_idle();
      case (VEC[v][33:32])
        2'd0: tag = "R2 R4 R5 R6";
        2'd1: tag = "R8 repeat";
        default: tag = "R10 both";
      endcase
      build(VEC[v][33:32] == 2'd1, VEC[v][31:16], VEC[v][15:0]);
      @(negedge clk);
      addr_i = VEC[v][31:16];
      cmd_i = VEC[v][15:0];
      start_i = (VEC[v][33:32] != 2'd1);
      repeat_i = (VEC[v][33:32] != 2'd0);
      play(0, $sformatf("%s R3 vec%0d", tag, v));
    end

    wait_idle();
    build(0, 16'h0042, 16'h5AA5);
    @(negedge clk);
    addr_i = 16'h0042; cmd_i = 16'h5AA5; start_i = 1;
    play(1, "R9 requests while busy");

    repeat (4) @(negedge clk);
    check(busy == 0 && ir_out == 0, "R9 no second frame", {busy, ir_out}, 0);

    build(1, 16'h0, 16'h0);
    @(negedge clk);
    repeat_i = 1;
    play(1, "R9 R8 requests during repeat");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule